// File: doc/BRIEF.md
# Parallel Branch Metric Unit for a Decision-Feedback Sequence Estimator

This block produces branch metrics for a reduced-state sequence estimator that covers binary GMSK, 8PSK, 16QAM and 32QAM bursts with a single datapath. A trellis state is handed in with the channel taps after pre-filtering, the survivor symbol indices of that state, the received sample and the state's accumulated metric. The unit first runs a fixed pre-processing pass. In that pass it convolves the survivor symbols with the trailing taps, one tap per cycle, and keeps the partial sum in a register.

Once the pass is done, eight candidate branches are evaluated in every cycle. Each branch rebuilds its expected received sample from the stored partial sum plus one complex product: the candidate symbol times the leading tap. The branch then forms the L1 distance to the received sample, adds the state metric and saturates the result. Alphabets larger than eight points are covered in several consecutive branch cycles. For the binary alphabet, the lanes that are not used are flagged as invalid. States enter through a valid/ready handshake. A new state can be accepted in the final branch cycle of the current one, so no idle cycle is lost between states.

Top module: `dfse_bmu`

## Requirements
- R1: Candidate and survivor symbols are taken from one computed point table, indexed by a symbol index n, with the mode input selecting the alphabet. Mode 0 (2 points) maps n=0 to (+6,0) and n=1 to (-6,0). Mode 1 (8 points) maps n=0..7 to (6,0),(4,4),(0,6),(-4,4),(-6,0),(-4,-4),(0,-6),(4,-4). Mode 2 (16 points) maps n to re=4*(n mod 4)-6 and im=4*(n div 4)-6. Mode 3 (32 points) walks a 6x6 grid of odd values from -5 to 5 with the four corners removed: rows run from im=+5 down to im=-5, points within a row run from re=-5 up to +5, and n counts the points in that order.
- R2: Survivor index k (k=1..TAPS-1) sits in bits [(k-1)*5 +: 5] of the survivor input. Only its low log2(M) bits are used, where M is the alphabet size. The symbol it selects is multiplied by tap k, and these products are summed with complex arithmetic into the partial sum.
- R3: In branch cycle g, lane l evaluates candidate index n=g*8+l. Its expected sample is the partial sum plus the product of candidate n and tap 0.
- R4: A valid lane outputs the state metric plus |rx_re-exp_re|+|rx_im-exp_im|, limited to 65535 (all ones in 16 bits).
- R5: A lane is valid exactly when n<M. An invalid lane outputs the all-ones metric, and lane 0 is always valid in a branch cycle.
- R6: A state uses ceil(M/8) branch cycles (1, 1, 2 or 4 for modes 0..3). out_group counts 0, 1, and so on through these cycles, and out_last is high only in the final one.
- R7: After the edge that accepts a state, TAPS-1 pre-processing cycles follow with out_valid and in_ready low. out_valid is first seen high after the (TAPS-1)th following rising edge.
- R8: in_ready is high while the unit is idle and during the final branch cycle. A state accepted in the final branch cycle starts pre-processing at once and does not disturb the metrics shown in that cycle.
- R9: After reset, in_ready is high, and out_valid and all lane valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Alphabet select (0: 2 pts, 1: 8 pts, 2: 16 pts, 3: 32 pts) |
| tap_re | input | TAPS*W | Real parts of the channel taps; tap k in [k*W +: W] |
| tap_im | input | TAPS*W | Imaginary parts of the channel taps |
| surv_i | input | (TAPS-1)*5 | Survivor symbol indices of the state |
| samp_re | input | W | Received sample, real part |
| samp_im | input | W | Received sample, imaginary part |
| smet_i | input | MW | Accumulated metric of the state |
| in_valid | input | 1 | State offered |
| in_ready | output | 1 | State accepted at the edge when in_valid is also high |
| out_valid | output | 1 | Branch cycle active |
| out_group | output | GW | Branch cycle number within the state |
| out_last | output | 1 | Final branch cycle of the state |
| out_lane_valid | output | LANES | Per-lane valid flags |
| out_metric | output | LANES*MW | Per-lane branch metric; lane l in [l*MW +: MW] |

## Verification
The two events that can share a cycle are the final branch cycle of one state and the acceptance of the next state. The bench provokes this by raising in_valid with fresh state data during the last group of a 2-point state. It then judges the old state's metrics in that same cycle against values computed from the old inputs. It also requires the new state's first branch cycle to arrive exactly TAPS-1 edges later, with metrics computed from the new inputs. A second chain sends a 32-point state straight after an 8-point one, which checks the hand-over across a change of alphabet size.

// File: rtl/dfse_bmu.sv
module dfse_bmu #(
  parameter int W     = 10,
  parameter int TAPS  = 4,
  parameter int MW    = 16,
  parameter int LANES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_i,
  input  logic [TAPS*W-1:0]        tap_re,
  input  logic [TAPS*W-1:0]        tap_im,
  input  logic [(TAPS-1)*5-1:0]    surv_i,
  input  logic [W-1:0]             samp_re,
  input  logic [W-1:0]             samp_im,
  input  logic [MW-1:0]            smet_i,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [((((32+LANES-1)/LANES)>1)?$clog2((32+LANES-1)/LANES):1)-1:0] out_group,
  output logic                     out_last,
  output logic [LANES-1:0]         out_lane_valid,
  output logic [LANES*MW-1:0]      out_metric
);
  localparam int SW    = 4;
  localparam int IW    = 5;
  localparam int NGMAX = (32 + LANES - 1) / LANES;
  localparam int GW    = (NGMAX > 1) ? $clog2(NGMAX) : 1;
  localparam int TW    = $clog2(TAPS);
  localparam int CW    = ((TW > GW) ? TW : GW) + 1;
  localparam int AW    = W + SW + TW + 1;
  localparam int DW    = AW + 1;
  localparam int SUMW  = ((DW > MW) ? DW : MW) + 2;
  localparam logic [MW-1:0] MAXM = '1;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_BR} phase_t;

  phase_t                  ph;
  logic [CW-1:0]           cnt;
  logic [1:0]              mode_r;
  logic [TAPS*W-1:0]       tre_r, tim_r;
  logic [(TAPS-1)*IW-1:0]  surv_r;
  logic signed [W-1:0]     sre_r, sim_r;
  logic [MW-1:0]           sm_r;
  logic signed [AW-1:0]    pre_r, pim_r;

  function automatic logic [2*SW-1:0] sym_lut(input logic [1:0] m, input logic [IW-1:0] n);
    int re, im, k;
    re = 0; im = 0; k = 0;
    case (m)
      2'd0: begin re = n[0] ? -6 : 6; im = 0; end
      2'd1: begin
        case (n[2:0])
          3'd0: begin re =  6; im =  0; end
          3'd1: begin re =  4; im =  4; end
          3'd2: begin re =  0; im =  6; end
          3'd3: begin re = -4; im =  4; end
          3'd4: begin re = -6; im =  0; end
          3'd5: begin re = -4; im = -4; end
          3'd6: begin re =  0; im = -6; end
          default: begin re = 4; im = -4; end
        endcase
      end
      2'd2: begin re = 4 * int'(n[1:0]) - 6; im = 4 * int'(n[3:2]) - 6; end
      default: begin
        k = int'(n);
        if (k < 4) begin im = 5; re = 2 * k - 3; end
        else if (k < 28) begin k = k - 4; im = 3 - 2 * (k / 6); re = 2 * (k % 6) - 5; end
        else begin k = k - 28; im = -5; re = 2 * k - 3; end
      end
    endcase
    return {re[SW-1:0], im[SW-1:0]};
  endfunction

  function automatic logic signed [AW-1:0] cmul(input logic signed [SW-1:0] a, input logic signed [W-1:0] b);
    return AW'(a) * AW'(b);
  endfunction

  logic [IW:0]    npts;
  logic [CW-1:0]  ngrp;
  logic           last, accept;

  always_comb begin
    case (mode_r)
      2'd0:    npts = 6'd2;
      2'd1:    npts = 6'd8;
      2'd2:    npts = 6'd16;
      default: npts = 6'd32;
    endcase
    ngrp = CW'((int'(npts) + LANES - 1) / LANES);
  end

  assign last      = (ph == S_BR) && (cnt == ngrp - 1'b1);
  assign in_ready  = (ph == S_IDLE) || last;
  assign accept    = in_valid && in_ready;
  assign out_valid = (ph == S_BR);
  assign out_last  = last;
  assign out_group = cnt[GW-1:0];

  logic [CW-1:0]        ksel, ssel;
  logic [IW-1:0]        smask, sidx;
  logic [2*SW-1:0]      ssym;
  logic signed [SW-1:0] s_re, s_im;
  logic signed [W-1:0]  tk_re, tk_im, t0_re, t0_im;
  logic signed [AW-1:0] pp_re, pp_im;

  assign ksel  = (cnt < CW'(TAPS)) ? cnt : '0;
  assign ssel  = (ksel == '0) ? '0 : ksel - 1'b1;
  assign smask = IW'(npts - 1'b1);
  assign sidx  = surv_r[ssel*IW +: IW] & smask;
  assign ssym  = sym_lut(mode_r, sidx);
  assign s_re  = ssym[2*SW-1:SW];
  assign s_im  = ssym[SW-1:0];
  assign tk_re = tre_r[ksel*W +: W];
  assign tk_im = tim_r[ksel*W +: W];
  assign t0_re = tre_r[W-1:0];
  assign t0_im = tim_r[W-1:0];
  assign pp_re = cmul(s_re, tk_re) - cmul(s_im, tk_im);
  assign pp_im = cmul(s_re, tk_im) + cmul(s_im, tk_re);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= S_IDLE;
      cnt    <= '0;
      mode_r <= '0;
      tre_r  <= '0;
      tim_r  <= '0;
      surv_r <= '0;
      sre_r  <= '0;
      sim_r  <= '0;
      sm_r   <= '0;
      pre_r  <= '0;
      pim_r  <= '0;
    end else if (accept) begin
      ph     <= S_PRE;
      cnt    <= CW'(1);
      mode_r <= mode_i;
      tre_r  <= tap_re;
      tim_r  <= tap_im;
      surv_r <= surv_i;
      sre_r  <= samp_re;
      sim_r  <= samp_im;
      sm_r   <= smet_i;
      pre_r  <= '0;
      pim_r  <= '0;
    end else begin
      case (ph)
        S_PRE: begin
          pre_r <= pre_r + pp_re;
          pim_r <= pim_r + pp_im;
          if (cnt == CW'(TAPS - 1)) begin
            ph  <= S_BR;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BR: begin
          if (last) begin
            ph  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int                   idx;
    logic                 ok;
    logic [2*SW-1:0]      cs;
    logic signed [SW-1:0] c_re, c_im;
    logic signed [AW-1:0] e_re, e_im;
    logic signed [DW-1:0] d_re, d_im;
    logic [DW-1:0]        a_re, a_im;
    logic [SUMW-1:0]      tot;

    always_comb begin
      idx  = int'(cnt) * LANES + l;
      ok   = (ph == S_BR) && (idx < int'(npts));
      cs   = sym_lut(mode_r, IW'(idx));
      c_re = cs[2*SW-1:SW];
      c_im = cs[SW-1:0];
      e_re = pre_r + cmul(c_re, t0_re) - cmul(c_im, t0_im);
      e_im = pim_r + cmul(c_re, t0_im) + cmul(c_im, t0_re);
      d_re = DW'(AW'(sre_r)) - DW'(e_re);
      d_im = DW'(AW'(sim_r)) - DW'(e_im);
      a_re = d_re[DW-1] ? DW'(-d_re) : DW'(d_re);
      a_im = d_im[DW-1] ? DW'(-d_im) : DW'(d_im);
      tot  = SUMW'(a_re) + SUMW'(a_im) + SUMW'(sm_r);
    end

    assign out_lane_valid[l]       = ok;
    assign out_metric[l*MW +: MW]  = !ok ? MAXM : ((tot > SUMW'(MAXM)) ? MAXM : tot[MW-1:0]);
  end
endmodule

module dfse_bmu_chk #(
  parameter int LANES = 8,
  parameter int MW    = 16,
  parameter int GW    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic [GW-1:0]       out_group,
  input logic                out_last,
  input logic [LANES-1:0]    out_lane_valid,
  input logic [LANES*MW-1:0] out_metric
);
  assert_pre_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);

  assert_ready_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (in_ready && out_valid));

  assert_group_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && out_group == $past(out_group) + 1'b1));

  assert_lanes_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_lane_valid == '0));

  assert_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lane_valid[0]);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_invalid_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_lane_valid[l]) |-> (out_metric[l*MW +: MW] == {MW{1'b1}}));
  end
endmodule

bind dfse_bmu dfse_bmu_chk #(.LANES(LANES), .MW(MW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_group(out_group), .out_last(out_last),
  .out_lane_valid(out_lane_valid), .out_metric(out_metric)
);

// File: tb/tb_dfse_bmu.sv
`timescale 1ns/1ps
module tb_dfse_bmu;
  localparam int W = 10, TAPS = 4, MW = 16, LANES = 8, GW = 2;

  logic                   clk = 0, rst_n = 0;
  logic [1:0]             mode_i = 0;
  logic [TAPS*W-1:0]      tap_re = 0, tap_im = 0;
  logic [(TAPS-1)*5-1:0]  surv_i = 0;
  logic [W-1:0]           samp_re = 0, samp_im = 0;
  logic [MW-1:0]          smet_i = 0;
  logic                   in_valid = 0;
  logic                   in_ready, out_valid, out_last;
  logic [GW-1:0]          out_group;
  logic [LANES-1:0]       out_lane_valid;
  logic [LANES*MW-1:0]    out_metric;

  dfse_bmu #(.W(W), .TAPS(TAPS), .MW(MW), .LANES(LANES)) dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;

  typedef struct {
    logic [1:0] m;
    int tre[TAPS];
    int tim[TAPS];
    int sv[TAPS-1];
    int rre, rim, sm;
  } stim_t;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mpts(input logic [1:0] m);
    return (m == 0) ? 2 : (m == 1) ? 8 : (m == 2) ? 16 : 32;
  endfunction

  task automatic ref_sym(input logic [1:0] m, input int n, output int re, output int im);
    int c;
    re = 0; im = 0;
    if (m == 0) begin re = (n == 0) ? 6 : -6; im = 0; end
    else if (m == 1) begin
      int pr[8] = '{6, 4, 0, -4, -6, -4, 0, 4};
      int pi[8] = '{0, 4, 6, 4, 0, -4, -6, -4};
      re = pr[n]; im = pi[n];
    end else if (m == 2) begin re = 4 * (n % 4) - 6; im = 4 * (n / 4) - 6; end
    else begin
      c = 0;
      for (int q = 5; q >= -5; q -= 2)
        for (int i = -5; i <= 5; i += 2) begin
          if (!((i == 5 || i == -5) && (q == 5 || q == -5))) begin
            if (c == n) begin re = i; im = q; end
            c++;
          end
        end
    end
  endtask

  task automatic drive(input stim_t s);
    mode_i = s.m;
    for (int k = 0; k < TAPS; k++) begin
      tap_re[k*W +: W] = W'(s.tre[k]);
      tap_im[k*W +: W] = W'(s.tim[k]);
    end
    for (int k = 0; k < TAPS-1; k++) surv_i[k*5 +: 5] = 5'(s.sv[k]);
    samp_re = W'(s.rre);
    samp_im = W'(s.rim);
    smet_i  = MW'(s.sm);
  endtask

  function automatic stim_t make(input logic [1:0] m, input int seed);
    stim_t s;
    s.m = m;
    for (int k = 0; k < TAPS; k++) begin
      s.tre[k] = ((seed * 37 + k * 53) % 181) - 90;
      s.tim[k] = ((seed * 29 + k * 71) % 161) - 80;
    end
    for (int k = 0; k < TAPS-1; k++) s.sv[k] = (seed * 7 + k * 11) % 32;
    s.rre = ((seed * 91) % 801) - 400;
    s.rim = ((seed * 57) % 701) - 350;
    s.sm  = seed * 100;
    return s;
  endfunction

  task automatic send(input stim_t s);
    @(negedge clk);
    drive(s);
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // Called just after the accepting edge; checks latency and all branch cycles.
  task automatic check_state(input stim_t a, input bit chain, input stim_t b, input string tag);
    int M, ng, k, pre, pim, sr, si, cr, ci, er, ei, bm, exp;
    M = mpts(a.m);
    ng = (M + LANES - 1) / LANES;
    pre = 0; pim = 0;
    for (int t = 1; t < TAPS; t++) begin
      ref_sym(a.m, a.sv[t-1] % M, sr, si);
      pre += sr * a.tre[t] - si * a.tim[t];
      pim += sr * a.tim[t] + si * a.tre[t];
    end
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (k == 1) in_valid = 0;
      if (out_valid || k > 20) break;
      chk(in_ready == 0, "R7", {tag, " ready low in pre"}, int'(in_ready), 0);
    end
    chk(k == TAPS, "R7", {tag, " first branch latency"}, k, TAPS);
    for (int g = 0; g < ng; g++) begin
      if (g > 0) @(negedge clk);
      chk(out_valid == 1, "R6", {tag, " out_valid"}, int'(out_valid), 1);
      chk(int'(out_group) == g, "R6", {tag, " group"}, int'(out_group), g);
      chk(out_last == (g == ng - 1), "R6", {tag, " last"}, int'(out_last), int'(g == ng - 1));
      for (int l = 0; l < LANES; l++) begin
        int n = g * LANES + l;
        if (n < M) begin
          ref_sym(a.m, n, cr, ci);
          er = pre + cr * a.tre[0] - ci * a.tim[0];
          ei = pim + cr * a.tim[0] + ci * a.tre[0];
          bm = ((a.rre - er) < 0 ? er - a.rre : a.rre - er) + ((a.rim - ei) < 0 ? ei - a.rim : a.rim - ei);
          exp = a.sm + bm;
          if (exp > 65535) exp = 65535;
          chk(out_lane_valid[l] == 1, "R5", {tag, " lane valid"}, int'(out_lane_valid[l]), 1);
          chk(int'(out_metric[l*MW +: MW]) == exp, "R4", {tag, " metric"}, int'(out_metric[l*MW +: MW]), exp);
        end else begin
          chk(out_lane_valid[l] == 0, "R5", {tag, " lane invalid"}, int'(out_lane_valid[l]), 0);
          chk(int'(out_metric[l*MW +: MW]) == 65535, "R5", {tag, " invalid metric"}, int'(out_metric[l*MW +: MW]), 65535);
        end
      end
      if (g == ng - 1) begin
        chk(in_ready == 1, "R8", {tag, " ready on last"}, int'(in_ready), 1);
        if (chain) begin drive(b); in_valid = 1; end
      end
    end
    if (chain) @(posedge clk);
    else begin
      @(negedge clk);
      chk(out_valid == 0 && in_ready == 1, "R8", {tag, " idle after state"}, int'({out_valid, in_ready}), 1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1, "R9", "reset ready", int'(in_ready), 1);
    chk(out_valid == 0, "R9", "reset out_valid", int'(out_valid), 0);
    chk(out_lane_valid == 0, "R9", "reset lanes", int'(out_lane_valid), 0);
  endtask

  task automatic t_mode(input logic [1:0] m, input int seed, input string tag);
    stim_t s = make(m, seed);
    send(s);
    check_state(s, 0, s, tag);
  endtask

  task automatic t_saturate();
    stim_t s = make(2'd3, 9);
    s.sm = 65000;
    send(s);
    check_state(s, 0, s, "R4 saturation");
  endtask

  task automatic t_chain();
    stim_t a = make(2'd0, 4), b = make(2'd3, 12), c = make(2'd1, 6);
    send(a);
    check_state(a, 1, b, "R8 chain gmsk->qam32");
    check_state(b, 0, b, "R8 chain second");
    send(c);
    check_state(c, 1, b, "R8 chain psk->qam32");
    check_state(b, 0, b, "R8 chain third");
  endtask

  initial begin
    #(5.0 * 200000);
    total++; fails++;
    $display("FAIL R7 watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_mode(2'd0, 3, "R1 R2 R3 gmsk");
    t_mode(2'd1, 5, "R1 R3 psk8");
    t_mode(2'd2, 8, "R1 R6 qam16");
    t_mode(2'd3, 11, "R1 R6 qam32");
    t_mode(2'd0, 17, "R2 gmsk masked survivors");
    t_saturate();
    t_chain();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule